// File: doc/BRIEF.md
# Writeback Snoop Intervention Sequencer

This block decides who owns the DRAM port when a processor with an internal writeback cache shares memory with alternate bus masters, such as a DMA engine, an ISA-side master or a local-bus master. Data in the processor's cache may be newer than the copy in DRAM. For that reason, every read or write from an alternate master is first presented to the processor as a snoop. The block then samples the processor's active-low hit-modified line a fixed number of clocks later. When a modified line is reported, the processor gets the memory port for a full burst writeback. Only after that is the alternate master allowed to complete its access. When no hit is reported, the master goes straight to memory.

The block also orders the processor's own traffic. An eviction writeback is granted as a burst of a fixed number of data acknowledgements. A line-fill read is never granted while a writeback request is pending, so the dirty line always reaches memory before the refill. The alternate master sees a single ready pulse only after its own memory access has finished. Until then it simply waits.

The sequencer steps through these states:

| State | Meaning |
| --- | --- |
| IDLE | Decides between requests, in the order writeback, master, fill. |
| SNOOP | Strobes the snoop for one cycle. |
| WAIT_HITM | Counts out the sample window. |
| CPU_WB | Grants the writeback burst. |
| CPU_FILL | Grants the line fill. |
| MASTER_ACCESS | Grants the master until one acknowledgement. |
| DONE | A one-cycle release that pulses ready for master work. |

The transitions are:

- IDLE goes to CPU_WB, SNOOP or CPU_FILL.
- SNOOP goes to WAIT_HITM.
- WAIT_HITM goes to CPU_WB on a hit, or to MASTER_ACCESS on a miss.
- CPU_WB goes to MASTER_ACCESS for a snoop, or to DONE for an eviction.
- CPU_FILL goes to DONE.
- MASTER_ACCESS goes to DONE.
- DONE goes to IDLE.

Top module: `snpi_seq`

## Requirements
- R1: While reset is held, every output is low: snp_stb, snp_inv, am_rdy and all three grants, and snp_addr is zero.
- R2: When an alternate-master request is accepted in IDLE, snp_stb is high for exactly one cycle, in the following cycle. During that cycle snp_addr carries the latched request address and snp_inv carries the request's write flag (1 = write).
- R3: hitm_n is sampled only in the cycle that is HITM_DLY cycles after the strobe cycle. A low level in any other cycle, including while idle, changes nothing.
- R4: A low hitm_n at the sample point raises gnt_cpu_wb in the next cycle. The grant is held for exactly BEATS cycles that carry mem_ack, and only then does gnt_master rise. am_rdy stays low throughout.
- R5: A high hitm_n at the sample point raises gnt_master in the next cycle, and no writeback grant occurs for that request.
- R6: The master access ends at the first mem_ack under gnt_master. am_rdy then pulses high for exactly one cycle, in the following cycle, and only for alternate-master transactions.
- R7: Master writes are snooped with snp_inv = 1 and follow the same hit and miss paths as reads, so a dirty line is written back before the master's write is granted.
- R8: cpu_wb_req seen in IDLE grants gnt_cpu_wb for BEATS acknowledged cycles. It produces no snoop strobe and no ready pulse.
- R9: IDLE resolves requests in the order cpu_wb_req, then am_req, then cpu_fill_req. gnt_cpu_fill never rises after a decision cycle in which cpu_wb_req was high.
- R10: A line-fill grant is held for exactly BEATS acknowledged cycles.
- R11: At most one of gnt_cpu_wb, gnt_cpu_fill and gnt_master is high in any cycle.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| am_req | input | 1 | Alternate-master request, held until ready |
| am_write | input | 1 | Request is a write (1) or read (0) |
| am_addr | input | AW | Request address |
| am_rdy | output | 1 | One-cycle completion pulse to the master |
| snp_stb | output | 1 | Snoop strobe to the processor |
| snp_inv | output | 1 | Snoop is for a write (invalidate) |
| snp_addr | output | AW | Snoop address |
| hitm_n | input | 1 | Processor hit-modified indication, active low |
| cpu_wb_req | input | 1 | Processor writeback burst request |
| cpu_fill_req | input | 1 | Processor line-fill read request |
| mem_ack | input | 1 | Memory controller data acknowledgement per beat |
| gnt_cpu_wb | output | 1 | Memory granted to processor writeback |
| gnt_cpu_fill | output | 1 | Memory granted to processor line fill |
| gnt_master | output | 1 | Memory granted to the alternate master |

## Verification
The bench builds the block with HITM_DLY = 3, BEATS = 4 and AW = 12. A sample delay longer than the minimum leaves room for a hit-modified pulse one cycle early and one cycle late around the real window, and both must be ignored. Four beats with acknowledgements only on alternate cycles stretch each burst with wait states, so the beat counter must count acknowledgements rather than cycles. The narrow address keeps the expected snoop word, which is the write flag above the address, in a plain integer.

// File: rtl/snpi_pkg.sv
package snpi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE          = 3'd0,
        ST_SNOOP         = 3'd1,
        ST_WAIT_HITM     = 3'd2,
        ST_CPU_WB        = 3'd3,
        ST_CPU_FILL      = 3'd4,
        ST_MASTER_ACCESS = 3'd5,
        ST_DONE          = 3'd6
    } snp_state_e;

    typedef struct packed {
        logic stb;
        logic gnt_wb;
        logic gnt_fill;
        logic gnt_master;
        logic rdy;
    } snp_out_t;

endpackage

// File: rtl/snpi_tally.sv
// Wrapping event counter: flags the final step of a LIMIT-long run.
module snpi_tally #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic last
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == TOP) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == TOP);
endmodule

// File: rtl/snpi_outdec.sv
// Moore output decode of the sequencer state.
module snpi_outdec import snpi_pkg::*; (
    input  snp_state_e state,
    input  logic       svc_master,
    output snp_out_t   outs
);
    always_comb begin
        outs = '0;
        unique case (state)
            ST_IDLE:          outs = '0;
            ST_SNOOP:         outs.stb = 1'b1;
            ST_WAIT_HITM:     outs = '0;
            ST_CPU_WB:        outs.gnt_wb = 1'b1;
            ST_CPU_FILL:      outs.gnt_fill = 1'b1;
            ST_MASTER_ACCESS: outs.gnt_master = 1'b1;
            ST_DONE:          outs.rdy = svc_master;
            default:          outs = '0;
        endcase
    end
endmodule

// File: rtl/snpi_seq.sv
module snpi_seq import snpi_pkg::*; #(
    parameter int AW       = 32,
    parameter int BEATS    = 4,
    parameter int HITM_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          am_req,
    input  logic          am_write,
    input  logic [AW-1:0] am_addr,
    output logic          am_rdy,
    output logic          snp_stb,
    output logic          snp_inv,
    output logic [AW-1:0] snp_addr,
    input  logic          hitm_n,
    input  logic          cpu_wb_req,
    input  logic          cpu_fill_req,
    input  logic          mem_ack,
    output logic          gnt_cpu_wb,
    output logic          gnt_cpu_fill,
    output logic          gnt_master
);
    snp_state_e    st_q, st_d;
    logic          svc_master_q;
    logic          lat_wr_q;
    logic [AW-1:0] lat_addr_q;
    logic          take_master, take_cpu;
    logic          win_clr, win_last;
    logic          beat_clr, beat_last;
    snp_out_t      outs;

    // Decision in IDLE: writeback first, then master, then fill.
    assign take_master = (st_q == ST_IDLE) && !cpu_wb_req && am_req;
    assign take_cpu    = (st_q == ST_IDLE) && (cpu_wb_req || (!am_req && cpu_fill_req));

    // Sample window timer: runs only while waiting for hit-modified.
    assign win_clr = (st_q != ST_WAIT_HITM);

    snpi_tally #(.LIMIT(HITM_DLY)) u_win (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (win_clr),
        .step  (1'b1),
        .last  (win_last)
    );

    // Burst beat counter: counts acknowledged data beats of a processor burst.
    assign beat_clr = (st_q != ST_CPU_WB) && (st_q != ST_CPU_FILL);

    snpi_tally #(.LIMIT(BEATS)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (beat_clr),
        .step  (mem_ack),
        .last  (beat_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_master_q <= 1'b0;
            lat_wr_q     <= 1'b0;
            lat_addr_q   <= '0;
        end else if (take_master) begin
            svc_master_q <= 1'b1;
            lat_wr_q     <= am_write;
            lat_addr_q   <= am_addr;
        end else if (take_cpu) begin
            svc_master_q <= 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cpu_wb_req)        st_d = ST_CPU_WB;
                else if (am_req)       st_d = ST_SNOOP;
                else if (cpu_fill_req) st_d = ST_CPU_FILL;
            end
            ST_SNOOP:     st_d = ST_WAIT_HITM;
            ST_WAIT_HITM: begin
                if (win_last) st_d = hitm_n ? ST_MASTER_ACCESS : ST_CPU_WB;
            end
            ST_CPU_WB: begin
                if (mem_ack && beat_last)
                    st_d = svc_master_q ? ST_MASTER_ACCESS : ST_DONE;
            end
            ST_CPU_FILL: begin
                if (mem_ack && beat_last) st_d = ST_DONE;
            end
            ST_MASTER_ACCESS: begin
                if (mem_ack) st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    snpi_outdec u_dec (
        .state      (st_q),
        .svc_master (svc_master_q),
        .outs       (outs)
    );

    assign snp_stb      = outs.stb;
    assign snp_inv      = outs.stb & lat_wr_q;
    assign snp_addr     = lat_addr_q;
    assign gnt_cpu_wb   = outs.gnt_wb;
    assign gnt_cpu_fill = outs.gnt_fill;
    assign gnt_master   = outs.gnt_master;
    assign am_rdy       = outs.rdy;
endmodule

// File: rtl/snpi_seq_chk.sv
module snpi_seq_chk #(
    parameter int BEATS    = 4,
    parameter int HITM_DLY = 2
) (
    input logic clk,
    input logic rst_n,
    input logic snp_stb,
    input logic hitm_n,
    input logic mem_ack,
    input logic cpu_wb_req,
    input logic gnt_cpu_wb,
    input logic gnt_cpu_fill,
    input logic gnt_master,
    input logic am_rdy
);
    localparam int CW = $clog2(HITM_DLY + 2) + 1;
    localparam int BW = $clog2(BEATS + 1) + 1;
    localparam logic [CW-1:0] SAMPLE_AT  = CW'(HITM_DLY);
    localparam logic [CW-1:0] OUTCOME_AT = CW'(HITM_DLY + 1);

    logic [CW-1:0] since_q;
    logic          hit_q;
    logic [BW-1:0] wb_acks_q;

    // Cycles elapsed since the snoop strobe, and the level seen at the sample point.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (snp_stb)                                  since_q <= CW'(1);
            else if (since_q != '0 && since_q <= SAMPLE_AT) since_q <= since_q + 1'b1;
            else                                          since_q <= '0;
            if (since_q == SAMPLE_AT) hit_q <= !hitm_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          wb_acks_q <= '0;
        else if (gnt_cpu_wb) wb_acks_q <= wb_acks_q + BW'(mem_ack);
        else                 wb_acks_q <= '0;
    end

    p_grant_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_cpu_wb, gnt_cpu_fill, gnt_master}));

    p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        snp_stb |=> !snp_stb);

    p_hit_to_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == OUTCOME_AT) && hit_q |-> gnt_cpu_wb);

    p_miss_to_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == OUTCOME_AT) && !hit_q |-> gnt_master);

    p_wb_beats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gnt_cpu_wb) |-> (wb_acks_q == BW'(BEATS)));

    p_rdy_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        am_rdy |=> !am_rdy);

    p_rdy_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        am_rdy |-> $past(gnt_master && mem_ack));

    p_fill_after_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_cpu_fill) |-> $past(!cpu_wb_req));
endmodule

bind snpi_seq snpi_seq_chk #(.BEATS(BEATS), .HITM_DLY(HITM_DLY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snp_stb      (snp_stb),
    .hitm_n       (hitm_n),
    .mem_ack      (mem_ack),
    .cpu_wb_req   (cpu_wb_req),
    .gnt_cpu_wb   (gnt_cpu_wb),
    .gnt_cpu_fill (gnt_cpu_fill),
    .gnt_master   (gnt_master),
    .am_rdy       (am_rdy)
);

// File: tb/sim_snpi_seq.sv
module sim_snpi_seq;
    localparam int AW = 12;
    localparam int BEATS = 4;
    localparam int HD = 3;

    localparam int K_STB  = 1;
    localparam int K_WB   = 2;
    localparam int K_FILL = 3;
    localparam int K_MA   = 4;
    localparam int K_RDY  = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          am_req = 1'b0, am_write = 1'b0;
    logic [AW-1:0] am_addr = '0;
    logic          am_rdy, snp_stb, snp_inv;
    logic [AW-1:0] snp_addr;
    logic          hitm_n = 1'b1;
    logic          cpu_wb_req = 1'b0, cpu_fill_req = 1'b0, mem_ack = 1'b0;
    logic          gnt_cpu_wb, gnt_cpu_fill, gnt_master;

    snpi_seq #(.AW(AW), .BEATS(BEATS), .HITM_DLY(HD)) u0 (
        .clk(clk), .rst_n(rst_n), .am_req(am_req), .am_write(am_write),
        .am_addr(am_addr), .am_rdy(am_rdy), .snp_stb(snp_stb), .snp_inv(snp_inv),
        .snp_addr(snp_addr), .hitm_n(hitm_n), .cpu_wb_req(cpu_wb_req),
        .cpu_fill_req(cpu_fill_req), .mem_ack(mem_ack), .gnt_cpu_wb(gnt_cpu_wb),
        .gnt_cpu_fill(gnt_cpu_fill), .gnt_master(gnt_master)
    );

    typedef struct {
        int    kind;
        int    data;
        string req;
    } exp_t;

    exp_t expq[$];
    int   errors = 0;
    int   checks = 0;

    task automatic push_exp(input int k, input int d, input string r);
        exp_t e;
        e.kind = k; e.data = d; e.req = r;
        expq.push_back(e);
    endtask

    task automatic observe(input int k, input int d);
        exp_t e;
        checks++;
        if (expq.size() == 0) begin
            errors++;
            $display("FAIL stray event (R8/R9 ordering): actual kind=%0d data=%0h expected none", k, d);
        end else begin
            e = expq.pop_front();
            if (e.kind != k || e.data != d) begin
                errors++;
                $display("FAIL %s: actual kind=%0d data=%0h expected kind=%0d data=%0h",
                         e.req, k, d, e.kind, e.data);
            end
        end
    endtask

    // Monitor: turns port activity into events and compares them to the queue.
    task automatic monitor();
        bit p_wb = 0, p_fl = 0, p_ma = 0;
        int n_wb = 0, n_fl = 0, n_ma = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ((gnt_cpu_wb && !p_wb) || (gnt_cpu_fill && !p_fl) || (gnt_master && !p_ma)) begin
                    checks++;
                    if ($countones({gnt_cpu_wb, gnt_cpu_fill, gnt_master}) > 1) begin
                        errors++;
                        $display("FAIL R11: actual grants=%b expected at most one",
                                 {gnt_cpu_wb, gnt_cpu_fill, gnt_master});
                    end
                end
                if (snp_stb) observe(K_STB, (int'(snp_inv) << AW) | int'(snp_addr));
                if (gnt_cpu_wb && mem_ack) n_wb++;
                if (gnt_cpu_fill && mem_ack) n_fl++;
                if (gnt_master && mem_ack) n_ma++;
                if (p_wb && !gnt_cpu_wb)   begin observe(K_WB, n_wb); n_wb = 0; end
                if (p_fl && !gnt_cpu_fill) begin observe(K_FILL, n_fl); n_fl = 0; end
                if (p_ma && !gnt_master)   begin observe(K_MA, n_ma); n_ma = 0; end
                if (am_rdy) observe(K_RDY, 0);
                p_wb = gnt_cpu_wb; p_fl = gnt_cpu_fill; p_ma = gnt_master;
            end
        end
    endtask

    // Memory responder: acknowledges every other cycle while a grant is up.
    task automatic responder();
        bit tgl = 0;
        forever begin
            @(posedge clk);
            #1;
            tgl = !tgl;
            mem_ack = tgl && (gnt_cpu_wb || gnt_cpu_fill || gnt_master);
        end
    endtask

    // mode: 0 no hit, 1 hit in window, 2 hit one cycle early, 3 hit one cycle late
    task automatic master_op(input int addr, input bit wr, input int mode);
        @(posedge clk); #1;
        am_req = 1'b1; am_write = wr; am_addr = AW'(addr);
        do @(negedge clk); while (!snp_stb);
        repeat (HD - 1) @(posedge clk);
        #1 if (mode == 2) hitm_n = 1'b0;
        @(posedge clk); #1 hitm_n = (mode == 1) ? 1'b0 : 1'b1;
        @(posedge clk); #1 hitm_n = (mode == 3) ? 1'b0 : 1'b1;
        @(posedge clk); #1 hitm_n = 1'b1;
        do @(negedge clk); while (!am_rdy);
        @(posedge clk); #1 am_req = 1'b0;
    endtask

    task automatic cpu_op(input bit wb, input bit fill);
        @(posedge clk); #1;
        cpu_wb_req = wb; cpu_fill_req = fill;
        if (wb) begin
            do @(negedge clk); while (!gnt_cpu_wb);
            do @(negedge clk); while (gnt_cpu_wb);
            @(posedge clk); #1 cpu_wb_req = 1'b0;
        end
        if (fill) begin
            do @(negedge clk); while (!gnt_cpu_fill);
            do @(negedge clk); while (gnt_cpu_fill);
            @(posedge clk); #1 cpu_fill_req = 1'b0;
        end
    endtask

    task automatic gap();
        repeat (3) @(posedge clk);
    endtask

    function automatic int stbw(input bit wr, input int addr);
        return (int'(wr) << AW) | addr;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        fork
            begin
                repeat (50000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog (R1..): actual=hung expected=completion");
                finish_run();
            end
        join_none

        // R1: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({snp_stb, snp_inv, am_rdy, gnt_cpu_wb, gnt_cpu_fill, gnt_master} != 6'b0 || snp_addr != '0) begin
            errors++;
            $display("FAIL R1: actual outs=%b addr=%h expected 0",
                     {snp_stb, snp_inv, am_rdy, gnt_cpu_wb, gnt_cpu_fill, gnt_master}, snp_addr);
        end
        @(posedge clk); #1 rst_n = 1'b1;

        fork
            monitor();
            responder();
        join_none
        gap();

        // R3: hit-modified while idle has no effect (monitor flags any event)
        @(posedge clk); #1 hitm_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 hitm_n = 1'b1;
        gap();

        // R2 R5 R6: read miss
        push_exp(K_STB, stbw(0, 'h123), "R2");
        push_exp(K_MA, 1, "R5");
        push_exp(K_RDY, 0, "R6");
        master_op('h123, 0, 0);
        gap();

        // R4: read hit, writeback burst before master access
        push_exp(K_STB, stbw(0, 'h2A4), "R2");
        push_exp(K_WB, BEATS, "R4");
        push_exp(K_MA, 1, "R4");
        push_exp(K_RDY, 0, "R6");
        master_op('h2A4, 0, 1);
        gap();

        // R7: write miss and write hit
        push_exp(K_STB, stbw(1, 'hF0F), "R7");
        push_exp(K_MA, 1, "R7");
        push_exp(K_RDY, 0, "R7");
        master_op('hF0F, 1, 0);
        gap();
        push_exp(K_STB, stbw(1, 'h801), "R7");
        push_exp(K_WB, BEATS, "R7");
        push_exp(K_MA, 1, "R7");
        push_exp(K_RDY, 0, "R7");
        master_op('h801, 1, 1);
        gap();

        // R3: hit one cycle early and one cycle late are ignored
        push_exp(K_STB, stbw(0, 'h055), "R3");
        push_exp(K_MA, 1, "R3");
        push_exp(K_RDY, 0, "R3");
        master_op('h055, 0, 2);
        gap();
        push_exp(K_STB, stbw(0, 'h3C3), "R3");
        push_exp(K_MA, 1, "R3");
        push_exp(K_RDY, 0, "R3");
        master_op('h3C3, 0, 3);
        gap();

        // R8: eviction writeback alone
        push_exp(K_WB, BEATS, "R8");
        cpu_op(1, 0);
        gap();

        // R10: line fill alone
        push_exp(K_FILL, BEATS, "R10");
        cpu_op(0, 1);
        gap();

        // R9: eviction and fill together, writeback first
        push_exp(K_WB, BEATS, "R9");
        push_exp(K_FILL, BEATS, "R9");
        cpu_op(1, 1);
        gap();

        // R9: master beats fill
        push_exp(K_STB, stbw(0, 'h111), "R9");
        push_exp(K_MA, 1, "R9");
        push_exp(K_RDY, 0, "R9");
        push_exp(K_FILL, BEATS, "R9");
        fork
            master_op('h111, 0, 0);
            cpu_op(0, 1);
        join
        gap();

        // R9: writeback beats master
        push_exp(K_WB, BEATS, "R9");
        push_exp(K_STB, stbw(1, 'h777), "R9");
        push_exp(K_MA, 1, "R9");
        push_exp(K_RDY, 0, "R9");
        fork
            master_op('h777, 1, 0);
            cpu_op(1, 0);
        join
        repeat (10) @(posedge clk);

        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R6/R9: actual pending=%0d expected 0", expq.size());
        end
        finish_run();
    end
endmodule